// File: doc/BRIEF.md
# Accumulator ALU with Rotates

This block is the arithmetic and logic stage for an 8-bit accumulator datapath. Each cycle it receives an instruction byte together with the current accumulator, a register value and an immediate byte. It returns the new accumulator value, a write-enable for the accumulator and the new carry. Two-operand operations combine the accumulator with a register or with the immediate byte. Single-operand operations rotate or invert the accumulator, or act only on the carry.

The block does not fetch operands or pick registers. The surrounding datapath reads the register named by the low instruction bits and presents it on `reg_val`. It also places the byte that follows an immediate-form instruction on `imm_val`. The outputs are combinational. The only state is the carry flag, and it is updated only when `op_valid` is high.

Top module: `acc_alu`

## Requirements
- R1: Instruction bits 7:6 = 10 select the register form. Bits 5:3 pick the operation: 000 add, 001 add with carry, 010 subtract, 011 subtract with borrow, 100 AND, 101 XOR, 110 OR, 111 compare. The second operand is `reg_val`.
- R2: Bits 7:6 = 11 with bits 2:0 = 110 select the immediate form. It uses the same operation coding in bits 5:3, but the second operand is `imm_val`.
- R3: Add produces the 8-bit sum. Add with carry also adds the stored carry. In both cases the new carry is 1 exactly when the unsigned sum exceeds 255.
- R4: Subtract produces A minus the operand. Subtract with borrow also subtracts the stored carry. In both cases the new carry is 1 exactly when the unsigned result would be negative (a borrow).
- R5: Compare sets the carry exactly as subtract does, and it never asserts `acc_we`.
- R6: AND, XOR and OR write the bitwise result and clear the carry.
- R7: Instruction 0x07 rotates the accumulator left circularly. Bit 7 goes to bit 0 and is also copied into the carry.
- R8: Instruction 0x0F rotates the accumulator right circularly. Bit 0 goes to bit 7 and is also copied into the carry.
- R9: Instruction 0x17 rotates left through the carry: the old carry enters bit 0 and bit 7 becomes the carry. Instruction 0x1F rotates right through the carry: the old carry enters bit 7 and bit 0 becomes the carry.
- R10: Instruction 0x2F writes the inverted accumulator and leaves the carry unchanged.
- R11: Instruction 0x37 sets the carry to 1 and instruction 0x3F inverts it. Neither one writes the accumulator.
- R12: The stored carry is 0 after reset. It changes only on a clock edge where `op_valid` is high and the instruction is one of those above. While `op_valid` is low, `acc_we` is 0.
- R13: Any other instruction byte (for example 0x00, 0x27, 0x47, 0xC7) leaves `acc_we` at 0 and the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Strobe marking the instruction as valid this cycle |
| instr | input | 8 | Instruction byte |
| acc_in | input | 8 | Current accumulator |
| reg_val | input | 8 | Register operand for the register form |
| imm_val | input | 8 | Immediate operand for the immediate form |
| acc_out | output | 8 | New accumulator value |
| acc_we | output | 1 | Accumulator write-enable |
| carry_next | output | 1 | Carry value the operation produces |
| carry_q | output | 1 | Stored carry flag |

## Verification
The hardest cases are the ones whose result depends on the stored carry: add with carry, subtract with borrow and the two rotates through carry. The carry can only be set from the ports by a previous operation, so the bench first drives the flag to a known value with the set-carry or complement-carry instruction and then issues the carry-dependent operation. It runs each of these with the carry at 0 and again at 1. A further case checks that an operation presented with the strobe low leaves the flag unchanged, so that a following carry-dependent operation still sees the earlier value.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   typedef enum logic [2:0] {
      BIN_ADD = 3'b000, BIN_ADC = 3'b001, BIN_SUB = 3'b010, BIN_SBC = 3'b011,
      BIN_AND = 3'b100, BIN_XOR = 3'b101, BIN_OR  = 3'b110, BIN_CMP = 3'b111
   } bin_op_e;

   // Single-operand selector, equal to instruction bits 5:3 of the 00xxx111 row
   typedef enum logic [2:0] {
      UN_ROL  = 3'b000, UN_ROR  = 3'b001, UN_RCL = 3'b010, UN_RCR = 3'b011,
      UN_NONE = 3'b100, UN_INV  = 3'b101, UN_STC = 3'b110, UN_CMC = 3'b111
   } un_op_e;
endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
   import acc_alu_pkg::*;
(
   input  logic [7:0] instr,
   output logic       is_bin,
   output logic       use_imm,
   output bin_op_e    bin_op,
   output logic       is_un,
   output un_op_e     un_op
);
   logic reg_form, imm_form;

   always_comb begin
      reg_form = (instr[7:6] == 2'b10);
      imm_form = (instr[7:6] == 2'b11) && (instr[2:0] == 3'b110);
      is_bin   = reg_form | imm_form;
      use_imm  = imm_form;
      bin_op   = bin_op_e'(instr[5:3]);
      un_op    = un_op_e'(instr[5:3]);
      is_un    = (instr[7:6] == 2'b00) && (instr[2:0] == 3'b111)
                 && (instr[5:3] != 3'b100);
   end
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  bin_op_e           op,
   output logic [DATA_W-1:0] res,
   output logic              cout,
   output logic              wr
);
   localparam int EXT_W = DATA_W + 1;

   logic [EXT_W-1:0] sum_x, dif_x;
   logic             use_c;

   always_comb begin
      use_c = (op == BIN_ADC) || (op == BIN_SBC);
      sum_x = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, use_c & cin};
      dif_x = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, use_c & cin};
      wr    = (op != BIN_CMP);
      unique case (op)
         BIN_ADD, BIN_ADC: begin res = sum_x[DATA_W-1:0]; cout = sum_x[DATA_W]; end
         BIN_SUB, BIN_SBC,
         BIN_CMP:          begin res = dif_x[DATA_W-1:0]; cout = dif_x[DATA_W]; end
         BIN_AND:          begin res = a & b; cout = 1'b0; end
         BIN_XOR:          begin res = a ^ b; cout = 1'b0; end
         default:          begin res = a | b; cout = 1'b0; end
      endcase
   end
endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic              cin,
   input  un_op_e            op,
   output logic [DATA_W-1:0] res,
   output logic              cout,
   output logic              wr
);
   localparam int MSB = DATA_W - 1;

   logic fill_l, fill_r;
   logic [DATA_W-1:0] rot_l, rot_r;

   assign fill_l = (op == UN_RCL) ? cin : a[MSB];
   assign fill_r = (op == UN_RCR) ? cin : a[0];

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == 0) begin : g_lo
         assign rot_l[i] = fill_l;
      end else begin : g_lsh
         assign rot_l[i] = a[i-1];
      end
      if (i == MSB) begin : g_hi
         assign rot_r[i] = fill_r;
      end else begin : g_rsh
         assign rot_r[i] = a[i+1];
      end
   end

   always_comb begin
      res  = a;
      cout = cin;
      wr   = 1'b1;
      unique case (op)
         UN_ROL, UN_RCL: begin res = rot_l; cout = a[MSB]; end
         UN_ROR, UN_RCR: begin res = rot_r; cout = a[0]; end
         UN_INV:         res = ~a;
         UN_STC:         begin cout = 1'b1; wr = 1'b0; end
         UN_CMC:         begin cout = ~cin; wr = 1'b0; end
         default:        wr = 1'b0;
      endcase
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [7:0]        instr,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] reg_val,
   input  logic [DATA_W-1:0] imm_val,
   output logic [DATA_W-1:0] acc_out,
   output logic              acc_we,
   output logic              carry_next,
   output logic              carry_q
);
   if (DATA_W < 2) begin : g_chk_w
      $error("acc_alu: DATA_W must be at least 2");
   end

   logic              is_bin, use_imm, is_un;
   bin_op_e           bin_op;
   un_op_e            un_op;
   logic [DATA_W-1:0] opnd, ar_res, ro_res;
   logic              ar_c, ar_wr, ro_c, ro_wr;

   acc_alu_decode u_dec (
      .instr(instr), .is_bin(is_bin), .use_imm(use_imm),
      .bin_op(bin_op), .is_un(is_un), .un_op(un_op)
   );

   assign opnd = use_imm ? imm_val : reg_val;

   acc_alu_arith #(.DATA_W(DATA_W)) u_ar (
      .a(acc_in), .b(opnd), .cin(carry_q), .op(bin_op),
      .res(ar_res), .cout(ar_c), .wr(ar_wr)
   );

   acc_alu_rotate #(.DATA_W(DATA_W)) u_ro (
      .a(acc_in), .cin(carry_q), .op(un_op),
      .res(ro_res), .cout(ro_c), .wr(ro_wr)
   );

   always_comb begin
      if (is_bin) begin
         acc_out = ar_res; carry_next = ar_c; acc_we = op_valid & ar_wr;
      end else if (is_un) begin
         acc_out = ro_res; carry_next = ro_c; acc_we = op_valid & ro_wr;
      end else begin
         acc_out = acc_in; carry_next = carry_q; acc_we = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         carry_q <= 1'b0;
      else if (op_valid & (is_bin | is_un)) carry_q <= carry_next;
   end

   // Strobe low keeps the flag and blocks writes
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(carry_q));
   p_nowe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> !acc_we);
   // Compare never writes the accumulator
   p_cmp_nowr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_bin && bin_op == BIN_CMP) |-> !acc_we);
   // Logic operations leave the carry cleared
   p_logic_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_bin && bin_op[2] && bin_op != BIN_CMP) |=> !carry_q);
   p_stc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && instr == 8'h37) |=> carry_q);
   p_cmc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && instr == 8'h3F) |=> (carry_q != $past(carry_q)));
   p_other_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_bin && !is_un) |=> $stable(carry_q));
endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [7:0] instr = 8'h00, acc_in = 8'h00, reg_val = 8'h00, imm_val = 8'h00;
   logic [7:0] acc_out;
   logic       acc_we, carry_next, carry_q;

   int n_run = 0, n_fail = 0;
   logic m_c = 1'b0;   // bench copy of the stored carry

   always #2.5 clk = ~clk;

   acc_alu uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .instr(instr),
      .acc_in(acc_in), .reg_val(reg_val), .imm_val(imm_val),
      .acc_out(acc_out), .acc_we(acc_we), .carry_next(carry_next),
      .carry_q(carry_q)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Reference: returns {known, we, carry, acc}
   function automatic logic [10:0] ref_model(input logic [7:0] ins, input logic [7:0] a,
                                             input logic [7:0] rv, input logic [7:0] iv,
                                             input logic c);
      int x, b, s;
      logic [2:0] f;
      f = ins[5:3];
      if (ins[7:6] == 2'b10 || (ins[7:6] == 2'b11 && ins[2:0] == 3'b110)) begin
         b = (ins[7:6] == 2'b11) ? int'(iv) : int'(rv);
         x = int'(a);
         case (f)
            3'd0, 3'd1: begin s = x + b + ((f == 3'd1) ? int'(c) : 0);
                              return {1'b1, 1'b1, s > 255, 8'(s)}; end
            3'd2, 3'd3, 3'd7: begin s = x - b - ((f == 3'd3) ? int'(c) : 0);
                              return {1'b1, f != 3'd7, s < 0, 8'(s)}; end
            3'd4: return {1'b1, 1'b1, 1'b0, a & 8'(b)};
            3'd5: return {1'b1, 1'b1, 1'b0, a ^ 8'(b)};
            default: return {1'b1, 1'b1, 1'b0, a | 8'(b)};
         endcase
      end
      case (ins)
         8'h07: return {1'b1, 1'b1, a[7], a[6:0], a[7]};
         8'h0F: return {1'b1, 1'b1, a[0], a[0], a[7:1]};
         8'h17: return {1'b1, 1'b1, a[7], a[6:0], c};
         8'h1F: return {1'b1, 1'b1, a[0], c, a[7:1]};
         8'h2F: return {1'b1, 1'b1, c, ~a};
         8'h37: return {1'b1, 1'b0, 1'b1, a};
         8'h3F: return {1'b1, 1'b0, ~c, a};
         default: return {1'b0, 1'b0, c, a};
      endcase
   endfunction

   task automatic step(input string req, input logic [7:0] ins, input logic [7:0] a,
                       input logic [7:0] rv, input logic [7:0] iv, input logic v);
      logic [10:0] e;
      @(negedge clk);
      instr = ins; acc_in = a; reg_val = rv; imm_val = iv; op_valid = v;
      #1;
      e = ref_model(ins, a, rv, iv, m_c);
      chk(req, "acc_we", int'(acc_we), int'(e[9] & v));
      if (e[9] & v) chk(req, "acc_out", int'(acc_out), int'(e[7:0]));
      chk(req, "carry_next", int'(carry_next), int'(e[8]));
      @(posedge clk); #1;
      if (v && e[10]) m_c = e[8];
      chk(req, "carry_q", int'(carry_q), int'(m_c));
   endtask

   task automatic set_c(input logic c);
      step("R11", c ? 8'h37 : 8'h37, 8'h00, 8'h00, 8'h00, 1'b1);
      if (!c) step("R11", 8'h3F, 8'h00, 8'h00, 8'h00, 1'b1);
   endtask

   task automatic t_reset;
      @(negedge clk); chk("R12", "carry after reset", int'(carry_q), 0);
      chk("R12", "acc_we idle", int'(acc_we), 0);
   endtask

   task automatic t_reg_form;   // R1
      for (int k = 0; k < 64; k++) begin
         logic [7:0] ins;
         ins = {2'b10, 3'(k % 8), 3'($urandom)};
         step("R1", ins, 8'($urandom), 8'($urandom), 8'($urandom), 1'b1);
      end
   endtask

   task automatic t_imm_form;   // R2
      for (int k = 0; k < 64; k++) begin
         logic [7:0] ins;
         ins = {2'b11, 3'(k % 8), 3'b110};
         step("R2", ins, 8'($urandom), 8'($urandom), 8'($urandom), 1'b1);
      end
   endtask

   task automatic t_carry_edges;   // R3 R4 R5 R6
      step("R3", 8'h80, 8'hFF, 8'h01, 8'h00, 1'b1);
      chk("R3", "0xFF+1 carry", int'(carry_q), 1);
      step("R3", 8'hC6, 8'h7F, 8'h00, 8'h80, 1'b1);
      set_c(1'b1);
      step("R3", 8'h88, 8'hFE, 8'h01, 8'h00, 1'b1);   // ADC FE+1+1
      set_c(1'b1);
      step("R4", 8'h98, 8'h05, 8'h05, 8'h00, 1'b1);   // SBC 5-5-1 borrow
      set_c(1'b0);
      step("R4", 8'h98, 8'h05, 8'h05, 8'h00, 1'b1);
      step("R4", 8'h90, 8'h00, 8'h01, 8'h00, 1'b1);
      step("R5", 8'hB8, 8'h10, 8'h20, 8'h00, 1'b1);
      step("R5", 8'hFE, 8'h30, 8'h00, 8'h20, 1'b1);
      set_c(1'b1);
      step("R6", 8'hA0, 8'hF0, 8'h3C, 8'h00, 1'b1);
      set_c(1'b1);
      step("R6", 8'hEE, 8'hF0, 8'h00, 8'h3C, 1'b1);
      set_c(1'b1);
      step("R6", 8'hB0, 8'h0F, 8'h30, 8'h00, 1'b1);
   endtask

   task automatic t_rotates;   // R7 R8 R9
      for (int k = 0; k < 16; k++) begin
         set_c(k[0]);
         step("R7", 8'h07, 8'($urandom), 8'h00, 8'h00, 1'b1);
         set_c(k[1]);
         step("R8", 8'h0F, 8'($urandom), 8'h00, 8'h00, 1'b1);
         set_c(k[2]);
         step("R9", 8'h17, 8'($urandom), 8'h00, 8'h00, 1'b1);
         set_c(k[3]);
         step("R9", 8'h1F, 8'($urandom), 8'h00, 8'h00, 1'b1);
      end
      set_c(1'b1);
      step("R9", 8'h17, 8'h80, 8'h00, 8'h00, 1'b1);
      step("R9", 8'h1F, 8'h01, 8'h00, 8'h00, 1'b1);
   endtask

   task automatic t_flag_ops;   // R10 R11
      set_c(1'b1);
      step("R10", 8'h2F, 8'hA5, 8'h00, 8'h00, 1'b1);
      set_c(1'b0);
      step("R10", 8'h2F, 8'h00, 8'h00, 8'h00, 1'b1);
      step("R11", 8'h37, 8'h12, 8'h00, 8'h00, 1'b1);
      step("R11", 8'h3F, 8'h12, 8'h00, 8'h00, 1'b1);
      step("R11", 8'h3F, 8'h12, 8'h00, 8'h00, 1'b1);
   endtask

   task automatic t_strobe_low;   // R12
      set_c(1'b0);
      step("R12", 8'h37, 8'h00, 8'h00, 8'h00, 1'b0);
      chk("R12", "carry held", int'(carry_q), 0);
      step("R12", 8'h80, 8'hFF, 8'hFF, 8'h00, 1'b0);
      step("R12", 8'h88, 8'h01, 8'h01, 8'h00, 1'b1);   // ADC sees carry 0
   endtask

   task automatic t_other;   // R13
      logic [7:0] list [4] = '{8'h00, 8'h27, 8'h47, 8'hC7};
      for (int k = 0; k < 4; k++) begin
         set_c(k[0]);
         step("R13", list[k], 8'h99, 8'hFF, 8'hFF, 1'b1);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_reg_form();
      t_imm_form();
      t_carry_edges();
      t_rotates();
      t_flag_ops();
      t_strobe_low();
      t_other();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule